// File: doc/BRIEF.md
# Multi-Format Timer with Event Capture

A 32-bit general-purpose timer with a small synchronous register port. The counter steps on a count tick. That tick comes from one of four sources: every clock cycle, one of two one-cycle enable pulses, or rising edges on an external pin. A power-of-two prescaler divides the chosen source. The counter counts up or down. In free-running mode it wraps at the end of its range; in periodic mode it reloads from a load register. It counts either as a plain binary number or as a packed time of day with hundredths, seconds, minutes and hours, and the hours wrap at 23 or at 255.

A capture register takes a copy of the count when a selected one of 32 event strobes fires. Each terminal count raises an interrupt flag, which stays up until software writes to a clear register. The event sources and the interrupt controller sit outside the block.

Top module: `mf_timer`

## Requirements
- R1: Registers by word address `addr_i`: 0 load (read/write), 1 count value (read-only), 2 control (read/write), 3 interrupt clear (write-only, reads 0), 4 capture (read-only). Other addresses read 0. After reset, every register and `irq_o` are 0.
- R2: Control fields: bit 17 capture enable, 16:12 event select, 11:9 clock select, 8 count up (0 = down), 7 enable, 6 periodic (0 = free-running), 5:4 format, 3:0 prescale. Bits 31:18 read as 0.
- R3: A load write puts the written data into both the load register and the count value on the same edge. It takes priority over a count step in that cycle.
- R4: The count value changes by one step on each count tick while enable is 1. While enable is 0 it holds. Format 00 counts in binary.
- R5: In free-running mode, a down count from 0 goes to the format maximum, and an up count from the format maximum goes to 0. The binary maximum is all ones.
- R6: In periodic mode, a step from the terminal count (0 when counting down, the format maximum when counting up) loads the load register into the count value.
- R7: Formats 10 and 11 count time of day, held in binary per field: hundredths 0–99 in bits 7:0, seconds 0–59 in 15:8, minutes 0–59 in 23:16, hours in 31:24. Each field carries or borrows into the next. The hour maximum is 23 for format 10 and 255 for format 11. Format 01 behaves as binary.
- R8: A prescale code p gives one count tick for every 2^p source ticks (0 → 1, 4 → 16, 8 → 256, 15 → 32768). A control write restarts the division.
- R9: Clock select 000 gives a tick every cycle, 001 follows `tick_lf_i`, 010 follows `tick_aux_i`, and 011 counts rising edges of `ext_pin_i` after a two-stage synchronizer. Codes 1xx never count, and unselected sources have no effect.
- R10: When capture is enabled and the selected event strobe is high at an edge, the capture register takes the count value held before that edge. Otherwise the capture register holds.
- R11: A terminal-count step sets `irq_o` from the next cycle on. A write to the clear address lowers it. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| tick_lf_i | input | 1 | Enable pulse of the low-frequency source |
| tick_aux_i | input | 1 | Enable pulse of the auxiliary source |
| ext_pin_i | input | 1 | Asynchronous external count pin |
| evt_i | input | 32 | Event strobes for capture |
| irq_o | output | 1 | Pending interrupt flag |

## Verification
Random runs load values close to a terminal count and run across it, in every format and direction, so both wrap and reload are exercised. A design that wraps to the binary maximum while in a time-of-day format, or that misses the carry from hundredths up through hours, leaves the wrong count. Directed cases cover these:
- The prescaler at the edge of a division period: a design off by one cycle shows the count one step early or late.
- Capture of the value before the edge, where a design that captures afterwards reads one step off.
- Unselected sources and events, which must change nothing.
- External-pin edges, which must count once per rising edge and not once per cycle the pin is high.

// File: rtl/mft_pkg.sv
package mft_pkg;
  localparam int DATA_W = 32;
  localparam int EVT_W  = 5;
  localparam int NUM_EVT = 1 << EVT_W;
  localparam int PRE_W  = 15;
  localparam int CTRL_W = 18;
  localparam int NUM_FLD = 4;

  localparam logic [2:0] A_LOAD = 3'd0;
  localparam logic [2:0] A_VAL  = 3'd1;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_CLR  = 3'd3;
  localparam logic [2:0] A_CAP  = 3'd4;

  typedef enum logic [1:0] {
    FMT_BIN = 2'b00, FMT_RSV = 2'b01, FMT_TOD24 = 2'b10, FMT_TOD256 = 2'b11
  } fmt_e;

  typedef struct packed {
    logic             cap_en;
    logic [EVT_W-1:0] evt_sel;
    logic [2:0]       clk_sel;
    logic             count_up;
    logic             enable;
    logic             periodic;
    fmt_e             fmt;
    logic [3:0]       prescale;
  } ctrl_t;
endpackage

// File: rtl/mft_tick_gen.sv
module mft_tick_gen import mft_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] clk_sel_i,
  input  logic [3:0] prescale_i,
  input  logic       restart_i,
  input  logic       tick_lf_i,
  input  logic       tick_aux_i,
  input  logic       ext_pin_i,
  output logic       tick_o
);
  logic [2:0]       ext_q;   // [0] sync1, [1] sync2, [2] previous
  logic             ext_rise;
  logic             src_tick;
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= '0;
    else         ext_q <= {ext_q[1:0], ext_pin_i};
  end
  assign ext_rise = ext_q[1] & ~ext_q[2];

  always_comb begin
    unique case (clk_sel_i)
      3'd0:    src_tick = 1'b1;
      3'd1:    src_tick = tick_lf_i;
      3'd2:    src_tick = tick_aux_i;
      3'd3:    src_tick = ext_rise;
      default: src_tick = 1'b0;
    endcase
  end

  // mask wraps to all ones for code 15 -> divide by 2^15
  assign pre_mask = PRE_W'((32'd1 << prescale_i) - 32'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_cnt <= '0;
    else if (restart_i) pre_cnt <= '0;
    else if (src_tick)  pre_cnt <= pre_cnt + 1'b1;
  end

  assign tick_o = src_tick && ((pre_cnt & pre_mask) == pre_mask);

  a_r9_no_tick_off_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_sel_i[2] |-> !tick_o);
  a_r8_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (pre_cnt == '0));
endmodule

// File: rtl/mft_step.sv
module mft_step import mft_pkg::*; (
  input  logic [DATA_W-1:0] val_i,
  input  logic [DATA_W-1:0] load_i,
  input  fmt_e              fmt_i,
  input  logic              up_i,
  input  logic              periodic_i,
  output logic [DATA_W-1:0] nxt_o,
  output logic              term_o
);
  logic              tod;
  logic [7:0]        hmax;
  logic [DATA_W-1:0] max_val;
  logic [DATA_W-1:0] tod_nxt;
  logic              cy;
  logic [7:0]        fld;
  logic [7:0]        lim;

  assign tod     = (fmt_i == FMT_TOD24) || (fmt_i == FMT_TOD256);
  assign hmax    = (fmt_i == FMT_TOD24) ? 8'd23 : 8'd255;
  assign max_val = tod ? {hmax, 8'd59, 8'd59, 8'd99} : '1;
  assign term_o  = up_i ? (val_i == max_val) : (val_i == '0);

  // ripple carry/borrow across the packed fields
  always_comb begin
    cy      = 1'b1;
    tod_nxt = val_i;
    fld     = '0;
    lim     = '0;
    for (int i = 0; i < NUM_FLD; i++) begin
      fld = val_i[8*i +: 8];
      lim = (i == NUM_FLD-1) ? hmax : ((i == 0) ? 8'd99 : 8'd59);
      if (cy) begin
        if (up_i) begin
          if (fld == lim) fld = '0;
          else begin fld = fld + 8'd1; cy = 1'b0; end
        end else begin
          if (fld == '0) fld = lim;
          else begin fld = fld - 8'd1; cy = 1'b0; end
        end
      end
      tod_nxt[8*i +: 8] = fld;
    end
  end

  always_comb begin
    if (term_o)   nxt_o = periodic_i ? load_i : (up_i ? '0 : max_val);
    else if (tod) nxt_o = tod_nxt;
    else          nxt_o = up_i ? val_i + 1'b1 : val_i - 1'b1;
  end
endmodule

// File: rtl/mf_timer.sv
module mf_timer import mft_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [2:0]         addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               tick_lf_i,
  input  logic               tick_aux_i,
  input  logic               ext_pin_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               irq_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] load_q, val_q, cap_q;
  logic              irq_q;
  logic              load_wr, ctrl_wr, clr_wr;
  logic              tick, cnt_step, term, wrap, cap_hit;
  logic [DATA_W-1:0] val_nxt;

  assign load_wr = we_i && (addr_i == A_LOAD);
  assign ctrl_wr = we_i && (addr_i == A_CTRL);
  assign clr_wr  = we_i && (addr_i == A_CLR);

  mft_tick_gen i_tick (
    .clk_i, .rst_ni,
    .clk_sel_i  (ctrl_q.clk_sel),
    .prescale_i (ctrl_q.prescale),
    .restart_i  (ctrl_wr),
    .tick_lf_i, .tick_aux_i, .ext_pin_i,
    .tick_o     (tick)
  );

  mft_step i_step (
    .val_i      (val_q),
    .load_i     (load_q),
    .fmt_i      (ctrl_q.fmt),
    .up_i       (ctrl_q.count_up),
    .periodic_i (ctrl_q.periodic),
    .nxt_o      (val_nxt),
    .term_o     (term)
  );

  assign cnt_step = ctrl_q.enable && tick;
  assign wrap     = cnt_step && term && !load_wr;
  assign cap_hit  = ctrl_q.cap_en && evt_i[ctrl_q.evt_sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '0;
      val_q  <= '0;
      cap_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (load_wr) begin
        load_q <= wdata_i;
        val_q  <= wdata_i;
      end else if (cnt_step) begin
        val_q  <= val_nxt;
      end
      if (cap_hit)     cap_q <= val_q;
      if (wrap)        irq_q <= 1'b1;
      else if (clr_wr) irq_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_LOAD:  rdata_o = load_q;
      A_VAL:   rdata_o = val_q;
      A_CTRL:  rdata_o = DATA_W'(ctrl_q);
      A_CAP:   rdata_o = cap_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q;

  a_r3_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_wr |=> (val_q == $past(wdata_i)) && (load_q == $past(wdata_i)));
  a_r4_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_step && !load_wr) |=> $stable(val_q));
  a_r6_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && ctrl_q.periodic) |=> (val_q == $past(load_q)));
  a_r10_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_hit |=> (cap_q == $past(val_q)));
  a_r10_cap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_hit |=> $stable(cap_q));
  a_r11_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> irq_o);
  a_r11_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !wrap) |=> !irq_o);
endmodule

// File: tb/test_mf_timer.sv
module test_mf_timer;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        tick_lf = 1'b0, tick_aux = 1'b0, ext_pin = 1'b0;
  logic [31:0] evt = '0;
  logic        irq;
  int unsigned n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mf_timer i_mf_timer (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tick_lf_i(tick_lf), .tick_aux_i(tick_aux),
    .ext_pin_i(ext_pin), .evt_i(evt), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic logic [31:0] mk_ctrl(bit cap, logic [4:0] sel, logic [2:0] cs,
      bit up, bit en, bit per, logic [1:0] fmt, logic [3:0] pre);
    return {14'b0, cap, sel, cs, up, en, per, fmt, pre};
  endfunction

  function automatic logic [31:0] fmax(logic [1:0] f);
    if (f[1]) return {(f == 2'b11) ? 8'd255 : 8'd23, 8'd59, 8'd59, 8'd99};
    return '1;
  endfunction

  function automatic int unsigned to_h(logic [31:0] v);
    return ((int'(v[31:24]) * 60 + int'(v[23:16])) * 60 + int'(v[15:8])) * 100 + int'(v[7:0]);
  endfunction

  function automatic logic [31:0] from_h(int unsigned h);
    int unsigned hu, s, m;
    hu = h % 100; h = h / 100;
    s = h % 60;   h = h / 60;
    m = h % 60;   h = h / 60;
    return {8'(h), 8'(m), 8'(s), 8'(hu)};
  endfunction

  function automatic logic [31:0] model_step(logic [31:0] v, logic [1:0] f, bit up,
      bit per, logic [31:0] ld, output bit wrapped);
    logic [31:0] mx;
    mx = fmax(f);
    wrapped = up ? (v == mx) : (v == 0);
    if (wrapped) return per ? ld : (up ? 32'd0 : mx);
    if (!f[1]) return up ? v + 1 : v - 1;
    return from_h(up ? to_h(v) + 1 : to_h(v) - 1);
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [31:0] d, v, exp_v, ld;
    bit          w, any_w;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, d); check("R1 load reset", d, 0);
    rd(3'd1, d); check("R1 value reset", d, 0);
    rd(3'd2, d); check("R1 ctrl reset", d, 0);
    rd(3'd4, d); check("R1 capture reset", d, 0);
    check("R1 irq reset", {31'b0, irq}, 0);

    // R2 reserved bits read zero (clock select 7 never counts)
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); check("R2 ctrl readback", d, 32'h0003_FFFF);
    rd(3'd3, d); check("R1 clear reads zero", d, 0);
    rd(3'd6, d); check("R1 unmapped reads zero", d, 0);
    wr(3'd2, 0);

    // R3 load, R4 hold while disabled
    wr(3'd0, 32'h1234_5678);
    rd(3'd1, d); check("R3 load copies value", d, 32'h1234_5678);
    repeat (10) @(negedge clk);
    rd(3'd1, d); check("R4 disabled holds", d, 32'h1234_5678);
    wr(3'd2, mk_ctrl(0, 0, 0, 0, 1, 0, 2'b00, 0));
    repeat (7) @(negedge clk);
    wr(3'd0, 32'd500);
    rd(3'd1, d); check("R3 load beats count", d, 32'd500);

    // R8 prescale /16
    wr(3'd2, 0); wr(3'd0, 0);
    wr(3'd2, mk_ctrl(0, 0, 0, 1, 1, 0, 2'b00, 4'd4));
    repeat (47) @(posedge clk); @(negedge clk);
    rd(3'd1, d); check("R8 prescale 16 before", d, 2);
    @(posedge clk); @(negedge clk);
    rd(3'd1, d); check("R8 prescale 16 at edge", d, 3);

    // R9 selected low-frequency source, aux ignored
    wr(3'd2, 0); wr(3'd0, 32'd10);
    wr(3'd2, mk_ctrl(0, 0, 3'd1, 0, 1, 0, 2'b00, 0));
    for (int i = 0; i < 5; i++) begin
      tick_lf = 1'b1; @(negedge clk); tick_lf = 1'b0;
      tick_aux = 1'b1; @(negedge clk); tick_aux = 1'b0; @(negedge clk);
    end
    rd(3'd1, d); check("R9 lf source counts, aux ignored", d, 5);
    wr(3'd2, mk_ctrl(0, 0, 3'd2, 0, 1, 0, 2'b00, 0));
    for (int i = 0; i < 4; i++) begin
      tick_aux = 1'b1; tick_lf = 1'b1; @(negedge clk);
      tick_aux = 1'b0; tick_lf = 1'b0; @(negedge clk);
    end
    rd(3'd1, d); check("R9 aux source counts", d, 1);
    wr(3'd2, mk_ctrl(0, 0, 3'd4, 0, 1, 0, 2'b00, 0));
    tick_aux = 1'b1; tick_lf = 1'b1; ext_pin = 1'b1;
    repeat (10) @(negedge clk);
    tick_aux = 1'b0; tick_lf = 1'b0; ext_pin = 1'b0;
    repeat (4) @(negedge clk);
    rd(3'd1, d); check("R9 select 100 never counts", d, 1);

    // R9 external pin rising edges
    wr(3'd2, 0); wr(3'd0, 0);
    wr(3'd2, mk_ctrl(0, 0, 3'd3, 1, 1, 0, 2'b00, 0));
    for (int i = 0; i < 3; i++) begin
      ext_pin = 1'b1; repeat (5) @(negedge clk);
      ext_pin = 1'b0; repeat (5) @(negedge clk);
    end
    rd(3'd1, d); check("R9 ext pin edges", d, 3);

    // R10 capture
    wr(3'd2, 0); wr(3'd0, 32'd1000);
    wr(3'd2, mk_ctrl(1, 5'd5, 0, 0, 1, 0, 2'b00, 0));
    repeat (20) @(negedge clk);
    rd(3'd1, v);
    evt[5] = 1'b1; @(negedge clk); evt[5] = 1'b0;
    rd(3'd4, d); check("R10 capture pre-edge value", d, v);
    evt[6] = 1'b1; @(negedge clk); evt[6] = 1'b0;
    rd(3'd4, d); check("R10 unselected event ignored", d, v);
    wr(3'd2, mk_ctrl(0, 5'd5, 0, 0, 1, 0, 2'b00, 0));
    evt = '1; @(negedge clk); evt = '0;
    rd(3'd4, d); check("R10 capture disabled", d, v);

    // R5/R11 free-running wrap and clear
    wr(3'd2, 0); wr(3'd3, 0); wr(3'd0, 32'd2);
    wr(3'd2, mk_ctrl(0, 0, 0, 0, 1, 0, 2'b00, 0));
    repeat (5) @(posedge clk); @(negedge clk);
    rd(3'd1, d); check("R5 binary down wrap", d, 32'hFFFF_FFFD);
    check("R11 irq set on wrap", {31'b0, irq}, 1);
    wr(3'd2, 0); wr(3'd3, 0);
    check("R11 irq cleared", {31'b0, irq}, 0);

    // R4-R7 random runs near terminal counts
    for (int it = 0; it < 48; it++) begin
      logic [1:0] f;
      bit up, per;
      int unsigned n, k, per_len;
      f   = 2'($urandom % 4);
      up  = 1'($urandom % 2);
      per = 1'($urandom % 2);
      n   = 1 + $urandom % 250;
      k   = $urandom % 200;
      per_len = (f == 2'b10) ? 24 * 360000 : 256 * 360000;
      case ($urandom % 3)
        0: ld = f[1] ? (up ? from_h(per_len - 1 - k) : from_h(k)) : (up ? 32'hFFFF_FFFF - k : k);
        1: ld = f[1] ? from_h((1 + $urandom % 20) * 360000 - k) : $urandom;
        default: ld = f[1] ? from_h((1 + $urandom % 59) * 6000 + k - 100) : k + 1;
      endcase
      wr(3'd2, 0); wr(3'd3, 0); wr(3'd0, ld);
      wr(3'd2, mk_ctrl(0, 0, 0, up, 1, per, f, 0));
      repeat (n) @(posedge clk); @(negedge clk);
      exp_v = ld; any_w = 0;
      for (int s = 0; s < int'(n); s++) begin
        exp_v = model_step(exp_v, f, up, per, ld, w);
        any_w |= w;
      end
      rd(3'd1, d);
      check($sformatf("R4 R5 R6 R7 random run %0d fmt %0d up %0d per %0d", it, f, up, per), d, exp_v);
      check($sformatf("R11 random run %0d irq", it), {31'b0, irq}, {31'b0, any_w});
    end

    done = 1'b1;
    report();
  end
endmodule